// File: doc/BRIEF.md
# Register Rename Map with Free List

This block is the tag side of a register renaming stage that handles one instruction per cycle. For every architectural register it records one of two things. Either the register points to the physical register of its youngest in-flight producer, or it points to the committed architectural copy. Each instruction's two sources are looked up combinationally in the same cycle. A destination takes a free physical register from a bitmap free list. The block returns each source's tag together with a flag that says whether the tag names a physical register or the architectural file.

At commit, the retiring instruction gives its architectural register and its physical register. The map entry goes back to pointing at the architectural copy only if no younger rename has overwritten it. The physical register then returns to the free list. A retire-time flush puts every entry back to architectural and marks every physical register free. There are no checkpoints. Value storage, wakeup and execution are outside this block: it moves tags only.

Top module: `rename_map_top`

## Requirements
- R1: After reset, every map entry reads as architectural (is_phys flag 0) and all PHYS_REGS physical registers are free.
- R2: A source lookup returns is_phys=1 and the tag of the physical register given to the most recent fired rename of that architectural register. This holds while no commit or flush has since cleared that mapping. Lookups are combinational on the current map.
- R3: When one instruction reads and writes the same architectural register, its source lookup returns the mapping from before that instruction's destination update.
- R4: A firing rename with a destination gets the lowest-numbered free physical register on dst_tag. That register stops being free from the next cycle.
- R5: When ren_dst_en is 1 and no physical register is free, ren_ready is 0, and the rename changes neither the map nor the free list.
- R6: A rename with ren_dst_en=0 needs no free register: ren_ready stays 1 (outside a flush) even when the free list is empty, and the instruction allocates nothing.
- R7: A commit whose physical register is still the mapping of its architectural register sets that entry back to architectural. The physical register is free from the next cycle.
- R8: A commit whose architectural register has since been renamed again leaves the map entry unchanged. It still frees the committed physical register.
- R9: When a rename writes the same architectural register that a commit would revert in the same cycle, the new rename mapping wins.
- R10: During a flush cycle ren_ready is 0. After the flush, every map entry is architectural, every physical register is free, and allocation starts again from register 0.
- R11: A register freed by commit cannot be allocated in the cycle of that commit. It becomes allocatable in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction is presented for rename |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_src_a | input | AW | First source architectural register |
| ren_src_b | input | AW | Second source architectural register |
| ren_dst_en | input | 1 | Instruction writes a destination |
| ren_dst | input | AW | Destination architectural register |
| src_a_tag | output | PW | Physical tag for the first source (valid when src_a_is_phys) |
| src_a_is_phys | output | 1 | 1: first source comes from a physical register, 0: from the architectural file |
| src_b_tag | output | PW | Physical tag for the second source |
| src_b_is_phys | output | 1 | Source flag for the second source |
| dst_tag | output | PW | Physical register allocated to the destination |
| cm_valid | input | 1 | An instruction with a destination commits |
| cm_arch | input | AW | Architectural register of the committing instruction |
| cm_phys | input | PW | Physical register of the committing instruction |
| flush | input | 1 | Retire-time flush: reset map and free list |

## Verification
The source tags, source flags, dst_tag and ren_ready all come combinationally from registered state. The bench therefore drives each vector at the falling edge and compares these outputs one time step later, against a model of the map and free list in the bench. The effect of a rename, commit or flush shows up exactly one rising edge later. The bench updates its model at that edge and compares again on the next vector. The sweep covers every architectural register from reset, fills the free list until it is empty, commits in order with and without a younger overwrite, and renames and commits the same register in one cycle. It also runs flushes and a long pseudo-random mix of legal traffic.

// File: rtl/rename_map_pkg.sv
package rename_map_pkg;

  localparam int unsigned MAX_PHYS = 256;

  // index of the lowest set bit among the first n bits, -1 if none
  function automatic int lowest_set(input logic [MAX_PHYS-1:0] v, input int n);
    int r;
    r = -1;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // a rename must wait when it needs a register and none is free, or on flush
  function automatic logic must_stall(input logic needs_dst, input logic none_free,
                                      input logic flushing);
    return flushing || (needs_dst && none_free);
  endfunction

  // a commit reverts an entry only if the entry still names its register
  function automatic logic entry_reverts(input logic is_phys, input logic tag_match,
                                         input logic arch_match);
    return is_phys && tag_match && arch_match;
  endfunction

endpackage

// File: rtl/rename_free_list.sv
module rename_free_list
  import rename_map_pkg::*;
#(
  parameter int PHYS_REGS = 16,
  localparam int PW = (PHYS_REGS > 1) ? $clog2(PHYS_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 alloc_en,
  input  logic                 rel_en,
  input  logic [PW-1:0]        rel_idx,
  output logic [PW-1:0]        alloc_idx,
  output logic                 empty,
  output logic [PHYS_REGS-1:0] free_vec
);

  logic [PHYS_REGS-1:0] free_q, free_d;
  logic [MAX_PHYS-1:0]  free_wide;
  int                   low;

  assign free_wide = MAX_PHYS'(free_q);
  assign free_vec  = free_q;
  assign empty     = (free_q == '0);

  always_comb begin
    low = lowest_set(free_wide, PHYS_REGS);
    if (low < 0) alloc_idx = '0;
    else         alloc_idx = PW'(low);
  end

  always_comb begin
    if (flush) begin
      free_d = '1;
    end else begin
      free_d = free_q;
      if (rel_en)   free_d[rel_idx]   = 1'b1;
      if (alloc_en) free_d[alloc_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= free_d;
  end

endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
  import rename_map_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = (ARCH_REGS > 1) ? $clog2(ARCH_REGS) : 1,
  localparam int PW = (PHYS_REGS > 1) ? $clog2(PHYS_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] rd_a_arch,
  input  logic [AW-1:0] rd_b_arch,
  output logic [PW-1:0] rd_a_tag,
  output logic          rd_a_phys,
  output logic [PW-1:0] rd_b_tag,
  output logic          rd_b_phys,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_arch,
  input  logic [PW-1:0] wr_tag,
  input  logic          cm_en,
  input  logic [AW-1:0] cm_arch,
  input  logic [PW-1:0] cm_tag
);

  logic [ARCH_REGS-1:0] phys_q;
  logic [PW-1:0]        tag_q [ARCH_REGS];

  assign rd_a_phys = phys_q[rd_a_arch];
  assign rd_a_tag  = tag_q[rd_a_arch];
  assign rd_b_phys = phys_q[rd_b_arch];
  assign rd_b_tag  = tag_q[rd_b_arch];

  for (genvar g = 0; g < ARCH_REGS; g++) begin : g_entry
    logic wr_hit, cm_hit;
    assign wr_hit = wr_en && (wr_arch == AW'(g));
    assign cm_hit = cm_en && entry_reverts(phys_q[g], tag_q[g] == cm_tag,
                                           cm_arch == AW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        phys_q[g] <= 1'b0;
        tag_q[g]  <= '0;
      end else if (flush) begin
        phys_q[g] <= 1'b0;
      end else if (wr_hit) begin
        phys_q[g] <= 1'b1;
        tag_q[g]  <= wr_tag;
      end else if (cm_hit) begin
        phys_q[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rename_map_top.sv
module rename_map_top
  import rename_map_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = (ARCH_REGS > 1) ? $clog2(ARCH_REGS) : 1,
  localparam int PW = (PHYS_REGS > 1) ? $clog2(PHYS_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic [AW-1:0] ren_src_a,
  input  logic [AW-1:0] ren_src_b,
  input  logic          ren_dst_en,
  input  logic [AW-1:0] ren_dst,
  output logic [PW-1:0] src_a_tag,
  output logic          src_a_is_phys,
  output logic [PW-1:0] src_b_tag,
  output logic          src_b_is_phys,
  output logic [PW-1:0] dst_tag,
  input  logic          cm_valid,
  input  logic [AW-1:0] cm_arch,
  input  logic [PW-1:0] cm_phys,
  input  logic          flush
);

  // named internal events, used by the bound checker
  logic                 ren_fire;
  logic                 alloc_fire;
  logic                 cm_release;
  logic                 fl_empty;
  logic [PHYS_REGS-1:0] free_vec;

  assign ren_ready  = !must_stall(ren_dst_en, fl_empty, flush);
  assign ren_fire   = ren_valid && ren_ready;
  assign alloc_fire = ren_fire && ren_dst_en;
  assign cm_release = cm_valid && !flush;

  rename_free_list #(.PHYS_REGS(PHYS_REGS)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .alloc_en (alloc_fire),
    .rel_en   (cm_release),
    .rel_idx  (cm_phys),
    .alloc_idx(dst_tag),
    .empty    (fl_empty),
    .free_vec (free_vec)
  );

  rename_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .rd_a_arch(ren_src_a),
    .rd_b_arch(ren_src_b),
    .rd_a_tag (src_a_tag),
    .rd_a_phys(src_a_is_phys),
    .rd_b_tag (src_b_tag),
    .rd_b_phys(src_b_is_phys),
    .wr_en    (alloc_fire),
    .wr_arch  (ren_dst),
    .wr_tag   (dst_tag),
    .cm_en    (cm_release),
    .cm_arch  (cm_arch),
    .cm_tag   (cm_phys)
  );

endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = (ARCH_REGS > 1) ? $clog2(ARCH_REGS) : 1,
  localparam int PW = (PHYS_REGS > 1) ? $clog2(PHYS_REGS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flush,
  input logic                 ren_valid,
  input logic                 ren_ready,
  input logic                 ren_dst_en,
  input logic [AW-1:0]        ren_dst,
  input logic [AW-1:0]        ren_src_a,
  input logic [PW-1:0]        src_a_tag,
  input logic                 src_a_is_phys,
  input logic [PW-1:0]        dst_tag,
  input logic                 alloc_fire,
  input logic                 cm_valid,
  input logic [PW-1:0]        cm_phys,
  input logic [PHYS_REGS-1:0] free_vec
);

  // R5
  no_alloc_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> free_vec != '0);

  // R5
  stall_holds_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && !ren_ready && !cm_valid && !flush) |=> $stable(free_vec));

  // R4
  alloc_takes_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !(cm_valid && cm_phys == dst_tag)) |=> !free_vec[$past(dst_tag)]);

  // R2
  new_mapping_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (ren_src_a != $past(ren_dst)) ||
                   (src_a_is_phys && src_a_tag == $past(dst_tag)));

  // R7
  commit_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !flush && !(alloc_fire && dst_tag == cm_phys)) |=> free_vec[$past(cm_phys)]);

  // R10
  flush_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> $countones(free_vec) == PHYS_REGS);

  // R10
  flush_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !ren_ready);

endmodule

bind rename_map_top rename_map_chk #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .ren_valid    (ren_valid),
  .ren_ready    (ren_ready),
  .ren_dst_en   (ren_dst_en),
  .ren_dst      (ren_dst),
  .ren_src_a    (ren_src_a),
  .src_a_tag    (src_a_tag),
  .src_a_is_phys(src_a_is_phys),
  .dst_tag      (dst_tag),
  .alloc_fire   (alloc_fire),
  .cm_valid     (cm_valid),
  .cm_phys      (cm_phys),
  .free_vec     (free_vec)
);

// File: tb/test_rename_map_top.sv
module test_rename_map_top;

  localparam int NA = 8;
  localparam int NP = 16;
  localparam int AW = 3;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0, ren_dst_en = 1'b0, cm_valid = 1'b0, flush = 1'b0;
  logic [AW-1:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0, cm_arch = '0;
  logic [PW-1:0] cm_phys = '0;
  logic ren_ready, src_a_is_phys, src_b_is_phys;
  logic [PW-1:0] src_a_tag, src_b_tag, dst_tag;

  always #5 clk = ~clk;

  rename_map_top #(.ARCH_REGS(NA), .PHYS_REGS(NP)) i_rename_map_top (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst_en(ren_dst_en),
    .ren_dst(ren_dst), .src_a_tag(src_a_tag), .src_a_is_phys(src_a_is_phys),
    .src_b_tag(src_b_tag), .src_b_is_phys(src_b_is_phys), .dst_tag(dst_tag),
    .cm_valid(cm_valid), .cm_arch(cm_arch), .cm_phys(cm_phys), .flush(flush)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model
  bit m_phys [NA];
  int m_tag  [NA];
  bit m_free [NP];
  int qa [32];
  int qp [32];
  int q_head = 0;
  int q_tail = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  function automatic int model_lowest();
    for (int i = 0; i < NP; i++) if (m_free[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NA; i++) begin m_phys[i] = 0; m_tag[i] = 0; end
    for (int i = 0; i < NP; i++) m_free[i] = 1;
    q_head = 0; q_tail = 0;
  endtask

  task automatic chk(input bit ok, input string lbl, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", lbl, what, act, exp);
    end
  endtask

  function automatic int src_code(input logic ph, input logic [PW-1:0] t);
    return ph ? (100 + int'(t)) : 0;
  endfunction

  // one cycle: drive at falling edge, compare, clock, update model
  task automatic cyc(input bit rv, input int s1, input int s2, input bit hd,
                     input int d, input bit cv, input bit fl, input string lbl);
    bit exp_ready, fire;
    int dexp, ca, cp, e1, e2;
    ca = cv ? qa[q_head % 32] : 0;
    cp = cv ? qp[q_head % 32] : 0;
    ren_valid = rv; ren_src_a = AW'(s1); ren_src_b = AW'(s2);
    ren_dst_en = hd; ren_dst = AW'(d);
    cm_valid = cv; cm_arch = AW'(ca); cm_phys = PW'(cp); flush = fl;
    #1;
    dexp = model_lowest();
    exp_ready = !fl && !(hd && dexp < 0);
    e1 = m_phys[s1] ? 100 + m_tag[s1] : 0;
    e2 = m_phys[s2] ? 100 + m_tag[s2] : 0;
    chk(src_code(src_a_is_phys, src_a_tag) == e1, lbl, "src_a", src_code(src_a_is_phys, src_a_tag), e1);
    chk(src_code(src_b_is_phys, src_b_tag) == e2, lbl, "src_b", src_code(src_b_is_phys, src_b_tag), e2);
    chk(ren_ready == exp_ready, lbl, "ren_ready", int'(ren_ready), int'(exp_ready));
    if (hd && exp_ready)
      chk(int'(dst_tag) == dexp, lbl, "dst_tag", int'(dst_tag), dexp);
    fire = rv && exp_ready;
    @(posedge clk);
    if (fl) begin
      model_reset();
    end else begin
      if (cv) begin
        m_free[cp] = 1;
        if (m_phys[ca] && m_tag[ca] == cp && !(fire && hd && d == ca)) m_phys[ca] = 0;
        q_head++;
      end
      if (fire && hd) begin
        m_free[dexp] = 0;
        m_phys[d] = 1; m_tag[d] = dexp;
        qa[q_tail % 32] = d; qp[q_tail % 32] = dexp; q_tail++;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: all entries architectural after reset
    for (int a = 0; a < NA; a++) cyc(0, a, NA-1-a, 0, 0, 0, 0, "R1");
    // R4 R3 R2: fill the free list in order
    for (int i = 0; i < NP; i++) cyc(1, (i+1) % NA, i % NA, 1, i % NA, 0, 0, "R2 R3 R4");
    // R5: no free register, destination needed
    cyc(1, 0, 1, 1, 2, 0, 0, "R5");
    for (int a = 0; a < NA; a++) cyc(0, a, a, 0, 0, 0, 0, "R5");
    // R6: no destination, still accepted
    cyc(1, 3, 4, 0, 0, 0, 0, "R6");
    // R11: commit frees, same-cycle rename still stalls
    cyc(1, 0, 0, 1, 5, 1, 0, "R11");
    cyc(1, 5, 0, 1, 5, 0, 0, "R11");
    // R8 then R7: commit the rest in order, reading every register
    for (int k = 0; q_head != q_tail && k < 40; k++)
      cyc(0, k % NA, (k+3) % NA, 0, 0, 1, 0, "R7 R8");
    for (int a = 0; a < NA; a++) cyc(0, a, a, 0, 0, 0, 0, "R7");
    // R10: flush with full list, then order restarts
    for (int i = 0; i < 5; i++) cyc(1, i, i, 1, i, 0, 0, "R4");
    cyc(1, 0, 1, 1, 6, 1, 1, "R10");
    for (int a = 0; a < NA; a++) cyc(0, a, a, 0, 0, 0, 0, "R10");
    cyc(1, 2, 2, 1, 2, 0, 0, "R10");
    // R9: rename and commit of the same register in one cycle
    cyc(1, 2, 2, 1, 2, 1, 0, "R9");
    cyc(0, 2, 2, 0, 0, 0, 0, "R9");
    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      bit rv, hd, cv, fl;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rv = lfsr[0] | lfsr[1];
      hd = lfsr[2] | lfsr[9];
      cv = lfsr[3] && (q_head != q_tail);
      fl = (lfsr[14:10] == 5'd0);
      cyc(rv, int'(lfsr[6:4]), int'(lfsr[19:17]), hd, int'(lfsr[24:22]), cv, fl,
          "R2 R4 R5 R7 R8 R9 R10");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule